// File: doc/BRIEF.md
# Masked Alarm Comparator with Shared Open-Drain Output

This block watches the current time of a clock core and raises a sticky alarm when the programmed alarm fields agree with it. There are five alarm fields: month, date, hours, minutes and seconds. Each alarm byte uses its top bit as an active-low enable. When that bit is clear, the field takes part in the comparison. When it is set, the field is ignored. Masking the fields in order makes the alarm repeat every second, minute, hour, day or month. The comparison runs once per one-second tick. A hit sets a flag, and the flag stays set until the host reads the status register.

One open-drain output pin is shared by three functions: the active-low alarm, a 512 Hz calibration tone, and a square wave of selectable frequency. The pin only ever pulls low or releases. A small decoder picks which function owns the pin. All the tones come from one free-running divider that advances on an oscillator enable pulse. One pulse arrives per half period of the 32768 Hz wave.

Top module: `alarm_out_top`

## Requirements
- R1: A field takes part in the match only when bit 7 of its alarm byte is 0. A match needs every such field's bits 6:0 to equal the corresponding current-time input, and fields with bit 7 = 1 are ignored whatever their value.
- R2: With bit 7 set in all five alarm bytes, every one-second tick sets the flag.
- R3: The match is only evaluated on a cycle with `sec_tick` = 1. A matching time without a tick leaves the flag unchanged, and the flag is visible on the cycle after the tick.
- R4: Once set, the flag holds until `status_rd` is pulsed. It reads 0 on the cycle after that pulse if no new match occurs in the same cycle.
- R5: When a status read and a matching tick fall in the same cycle, the flag ends up set.
- R6: With `cal_en` = 1, the pin follows the 512 Hz tone whatever the other mode inputs are: it is pulled low while bit 6 of the oscillator count is 0. Alarm matching keeps setting the flag in this mode.
- R7: With `cal_en` = 0 and `alm_sel` = 0, the pin carries the square wave chosen by `freq_sel`: 00 gives 1 Hz (count bit 15), 01 gives 512 Hz (bit 6), 10 gives 4096 Hz (bit 3) and 11 gives 32768 Hz (bit 0). The pin is pulled low while the chosen bit is 0.
- R8: With `cal_en` = 0, `alm_sel` = 1 and `alm_en` = 1, the pin is pulled low exactly while the flag is set.
- R9: With `cal_en` = 0, `alm_sel` = 1 and `alm_en` = 0, the pin is released even while the flag is set.
- R10: After reset the flag is 0 and the oscillator count is 0.
- R11: The oscillator count advances by one on each cycle with `osc_tick` = 1, holds otherwise, and wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-second evaluation pulse |
| osc_tick | input | 1 | Oscillator enable, one per half period of 32768 Hz |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 7 | Current hours, BCD |
| now_date | input | 7 | Current date, BCD |
| now_month | input | 7 | Current month, BCD |
| alm_sec | input | 8 | Seconds alarm byte, bit 7 active-low enable |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hour | input | 8 | Hours alarm byte |
| alm_date | input | 8 | Date alarm byte |
| alm_month | input | 8 | Month alarm byte |
| status_rd | input | 1 | Status register read strobe, clears the flag |
| cal_en | input | 1 | Calibration tone select |
| alm_en | input | 1 | Alarm pin enable |
| alm_sel | input | 1 | 1 = alarm function, 0 = square wave |
| freq_sel | input | 2 | Square-wave frequency code |
| alarm_flag | output | 1 | Sticky alarm flag |
| pin_pull_low | output | 1 | Open-drain enable, 1 pulls the pin low |

## Verification
The bench tests a mismatch placed in only one enabled field, and a mismatch in a masked field that must not block the match. A design that inverted or dropped an enable bit would fire, or stay silent, in one of these cases. It also tests a matching time with no tick, where a design that was not gated on the tick would set the flag, and a read that lands in the same cycle as a new match, where a design that gave the clear priority would lose the event. The decoder cases check that calibration overrides every other setting, that a disabled alarm releases the pin while the flag stays set, and that each frequency code picks its own divider bit. The 1 Hz case crosses the full half period.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int unsigned NUM_FIELDS = 5;
  localparam int unsigned TIME_W     = 7;
  localparam int unsigned ALM_W      = TIME_W + 1;
  localparam int unsigned DIV_W      = 16;

  typedef enum logic [1:0] {
    PIN_TONE  = 2'd0,
    PIN_WAVE  = 2'd1,
    PIN_ALARM = 2'd2,
    PIN_OFF   = 2'd3
  } pin_mode_e;

  typedef logic [NUM_FIELDS-1:0][TIME_W-1:0] time_vec_t;
  typedef logic [NUM_FIELDS-1:0][ALM_W-1:0]  alm_vec_t;
endpackage

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_pkg::*;
#(
  parameter int unsigned N_FLD = NUM_FIELDS,
  parameter int unsigned VAL_W = TIME_W
) (
  input  logic [N_FLD-1:0][VAL_W-1:0] now_vals,
  input  logic [N_FLD-1:0][VAL_W:0]   alm_vals,
  output logic                         hit
);
  localparam int unsigned EN_BIT = VAL_W;

  logic [N_FLD-1:0] fld_ok;

  for (genvar g = 0; g < N_FLD; g++) begin : g_fld
    logic ignored;
    logic equal;
    always_comb begin
      ignored   = alm_vals[g][EN_BIT];
      equal     = (alm_vals[g][VAL_W-1:0] == now_vals[g]);
      fld_ok[g] = ignored | equal;
    end
  end

  always_comb hit = &fld_ok;
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic hit,
  input  logic status_rd,
  output logic flag
);
  logic set_evt;
  logic flag_d;
  logic flag_q;

  always_comb begin
    set_evt = sec_tick & hit;
    flag_d  = flag_q;
    if (status_rd) flag_d = 1'b0;
    if (set_evt)   flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  assert_set_on_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && hit) |=> flag_q);
  assert_no_set_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !sec_tick) |=> !flag_q);
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !status_rd) |=> flag_q);
  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !(sec_tick && hit)) |=> !flag_q);
  assert_set_beats_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && sec_tick && hit) |=> flag_q);
endmodule

// File: rtl/alarm_divider.sv
module alarm_divider
  import alarm_pkg::*;
#(
  parameter int unsigned CNT_W    = DIV_W,
  parameter int unsigned TAP_1HZ  = 15,
  parameter int unsigned TAP_512  = 6,
  parameter int unsigned TAP_4K   = 3,
  parameter int unsigned TAP_32K  = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  output logic [3:0] waves,
  output logic       tone
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (osc_tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    waves[0] = cnt_q[TAP_1HZ];
    waves[1] = cnt_q[TAP_512];
    waves[2] = cnt_q[TAP_4K];
    waves[3] = cnt_q[TAP_32K];
    tone     = cnt_q[TAP_512];
  end

  assert_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    osc_tick |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_count_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_tick |=> $stable(cnt_q));
endmodule

// File: rtl/alarm_pin_mux.sv
module alarm_pin_mux
  import alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cal_en,
  input  logic       alm_en,
  input  logic       alm_sel,
  input  logic [1:0] freq_sel,
  input  logic [3:0] waves,
  input  logic       tone,
  input  logic       flag,
  output logic       pull_low
);
  pin_mode_e mode;
  logic      wave_lvl;

  always_comb begin
    if (cal_en)       mode = PIN_TONE;
    else if (!alm_sel) mode = PIN_WAVE;
    else if (alm_en)  mode = PIN_ALARM;
    else              mode = PIN_OFF;
  end

  always_comb wave_lvl = waves[freq_sel];

  always_comb begin
    unique case (mode)
      PIN_TONE:  pull_low = ~tone;
      PIN_WAVE:  pull_low = ~wave_lvl;
      PIN_ALARM: pull_low = flag;
      PIN_OFF:   pull_low = 1'b0;
      default:   pull_low = 1'b0;
    endcase
  end

  assert_tone_owns_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cal_en |-> (pull_low == !tone));
  assert_alarm_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_en && alm_sel && alm_en) |-> (pull_low == flag));
  assert_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_en && alm_sel && !alm_en) |-> !pull_low);
endmodule

// File: rtl/alarm_out_top.sv
module alarm_out_top
  import alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             osc_tick,
  input  logic [TIME_W-1:0] now_sec,
  input  logic [TIME_W-1:0] now_min,
  input  logic [TIME_W-1:0] now_hour,
  input  logic [TIME_W-1:0] now_date,
  input  logic [TIME_W-1:0] now_month,
  input  logic [ALM_W-1:0]  alm_sec,
  input  logic [ALM_W-1:0]  alm_min,
  input  logic [ALM_W-1:0]  alm_hour,
  input  logic [ALM_W-1:0]  alm_date,
  input  logic [ALM_W-1:0]  alm_month,
  input  logic             status_rd,
  input  logic             cal_en,
  input  logic             alm_en,
  input  logic             alm_sel,
  input  logic [1:0]       freq_sel,
  output logic             alarm_flag,
  output logic             pin_pull_low
);
  time_vec_t  now_v;
  alm_vec_t   alm_v;
  logic       hit;
  logic       flag;
  logic [3:0] waves;
  logic       tone;

  always_comb begin
    now_v = {now_month, now_date, now_hour, now_min, now_sec};
    alm_v = {alm_month, alm_date, alm_hour, alm_min, alm_sec};
  end

  alarm_match #(.N_FLD(NUM_FIELDS), .VAL_W(TIME_W)) u_match (
    .now_vals (now_v),
    .alm_vals (alm_v),
    .hit      (hit)
  );

  alarm_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .hit       (hit),
    .status_rd (status_rd),
    .flag      (flag)
  );

  alarm_divider #(.CNT_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_tick (osc_tick),
    .waves    (waves),
    .tone     (tone)
  );

  alarm_pin_mux u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .cal_en   (cal_en),
    .alm_en   (alm_en),
    .alm_sel  (alm_sel),
    .freq_sel (freq_sel),
    .waves    (waves),
    .tone     (tone),
    .flag     (flag),
    .pull_low (pin_pull_low)
  );

  assign alarm_flag = flag;

  assert_hit_needs_enabled_fields_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!alm_sec[TIME_W] && (alm_sec[TIME_W-1:0] != now_sec)) |-> !hit);
  assert_all_masked_fires_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && alm_sec[TIME_W] && alm_min[TIME_W] && alm_hour[TIME_W] &&
     alm_date[TIME_W] && alm_month[TIME_W]) |=> alarm_flag);
endmodule

// File: tb/test_alarm_out_top.sv
module test_alarm_out_top;
  logic       clk;
  logic       rst_n;
  logic       sec_tick, osc_tick, status_rd;
  logic [6:0] now_sec, now_min, now_hour, now_date, now_month;
  logic [7:0] alm_sec, alm_min, alm_hour, alm_date, alm_month;
  logic       cal_en, alm_en, alm_sel;
  logic [1:0] freq_sel;
  logic       alarm_flag, pin_pull_low;

  typedef struct {
    logic  flag;
    logic  pin;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  event sample_ev;
  int   checks = 0;
  int   fails  = 0;
  int   osc_cnt = 0;
  bit   done = 0;

  alarm_out_top i_alarm_out_top (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .osc_tick(osc_tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_date(now_date), .now_month(now_month),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
    .alm_date(alm_date), .alm_month(alm_month),
    .status_rd(status_rd), .cal_en(cal_en), .alm_en(alm_en),
    .alm_sel(alm_sel), .freq_sel(freq_sel),
    .alarm_flag(alarm_flag), .pin_pull_low(pin_pull_low)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        checks++;
        if (alarm_flag !== it.flag || pin_pull_low !== it.pin) begin
          fails++;
          $display("FAIL %s: flag=%b pin=%b expected flag=%b pin=%b",
                   it.tag, alarm_flag, pin_pull_low, it.flag, it.pin);
        end
      end
    end
  end

  // driver: one cycle of stimulus, expectation pushed after the edge
  // tap < 0: pin expectation is epin; otherwise pin low while count bit tap is 0
  task automatic step(input logic tk, input logic rd, input logic osc,
                      input logic eflag, input logic epin, input int tap,
                      input string tag, input bit chk = 1);
    exp_t it;
    @(negedge clk);
    sec_tick  = tk;
    status_rd = rd;
    osc_tick  = osc;
    @(posedge clk);
    if (osc) osc_cnt = (osc_cnt + 1) % 65536;
    #2;
    sec_tick = 1'b0; status_rd = 1'b0; osc_tick = 1'b0;
    if (chk) begin
      it.flag = eflag;
      it.pin  = (tap < 0) ? epin : !osc_cnt[tap];
      it.tag  = tag;
      exp_q.push_back(it);
      -> sample_ev;
      #1;
    end
  endtask

  task automatic set_time(input logic [6:0] s, m, h, d, mo);
    now_sec = s; now_min = m; now_hour = h; now_date = d; now_month = mo;
  endtask

  task automatic set_alm(input logic [7:0] s, m, h, d, mo);
    alm_sec = s; alm_min = m; alm_hour = h; alm_date = d; alm_month = mo;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual=expired expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sec_tick = 0; osc_tick = 0; status_rd = 0;
    cal_en = 0; alm_en = 1; alm_sel = 1; freq_sel = 2'b00;
    set_time(7'h00, 7'h00, 7'h00, 7'h01, 7'h01);
    set_alm(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R10 reset state, alarm mode pin released
    step(0, 0, 0, 0, 0, -1, "R10 reset flag clear");
    // R2 all masked: any tick fires; R8 pin follows flag
    step(1, 0, 0, 1, 1, -1, "R2 all masked tick sets flag / R8 pin low");
    step(0, 0, 0, 1, 1, -1, "R4 flag holds without read");
    step(0, 0, 0, 1, 1, -1, "R4 flag still held");
    step(0, 1, 0, 0, 0, -1, "R4 read clears flag and pin");

    // R1 seconds only
    set_alm(8'h25, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    set_time(7'h24, 7'h10, 7'h03, 7'h12, 7'h06);
    step(1, 0, 0, 0, 0, -1, "R1 seconds mismatch no fire");
    set_time(7'h25, 7'h10, 7'h03, 7'h12, 7'h06);
    step(0, 0, 0, 0, 0, -1, "R3 match without tick no fire");
    step(1, 0, 0, 1, 1, -1, "R1 seconds match fires");
    step(0, 1, 0, 0, 0, -1, "R4 clear after seconds alarm");

    // R1 all five enabled, mismatch in month only
    set_alm(8'h25, 8'h10, 8'h03, 8'h12, 8'h07);
    step(1, 0, 0, 0, 0, -1, "R1 month mismatch blocks");
    // month masked: the mismatched value is ignored
    set_alm(8'h25, 8'h10, 8'h03, 8'h12, 8'h87);
    step(1, 0, 0, 1, 1, -1, "R1 masked month ignored");
    step(0, 1, 0, 0, 0, -1, "R4 clear");
    // all enabled and equal
    set_alm(8'h25, 8'h10, 8'h03, 8'h12, 8'h06);
    step(1, 0, 0, 1, 1, -1, "R1 full match fires");
    // minutes mismatch while others match
    set_alm(8'h25, 8'h11, 8'h03, 8'h12, 8'h06);
    step(0, 1, 0, 0, 0, -1, "R4 clear");
    step(1, 0, 0, 0, 0, -1, "R1 minutes mismatch blocks");

    // R5 read and matching tick together
    set_alm(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    step(1, 0, 0, 1, 1, -1, "R2 set");
    step(1, 1, 0, 1, 1, -1, "R5 set wins over read");

    // R9 alarm pin disabled, flag kept
    alm_en = 0;
    step(0, 0, 0, 1, 0, -1, "R9 pin released with flag set");
    alm_en = 1;
    step(0, 0, 0, 1, 1, -1, "R8 pin low again");
    step(0, 1, 0, 0, 0, -1, "R4 clear");

    // R6 calibration overrides, alarm continues
    cal_en = 1; alm_sel = 0; alm_en = 0; freq_sel = 2'b11;
    step(0, 0, 0, 0, 0, 6, "R6 tone at count start");
    for (int i = 0; i < 140; i++)
      step(0, 0, 1, 0, 0, 6, "R6 tone follows 512 Hz tap");
    step(1, 0, 1, 1, 0, 6, "R6 alarm sets flag during tone");
    step(0, 1, 0, 0, 0, 6, "R4 clear in tone mode");
    alm_sel = 1; alm_en = 1;
    step(0, 0, 1, 0, 0, 6, "R6 tone ignores alarm mode bits");
    cal_en = 0;

    // R7 / R11 square wave taps
    alm_sel = 0;
    freq_sel = 2'b11;
    for (int i = 0; i < 6; i++) step(0, 0, 1, 0, 0, 0, "R7 32768 Hz tap");
    step(0, 0, 0, 0, 0, 0, "R11 count holds without osc tick");
    step(0, 0, 0, 0, 0, 0, "R11 count still held");
    freq_sel = 2'b10;
    for (int i = 0; i < 20; i++) step(0, 0, 1, 0, 0, 3, "R7 4096 Hz tap");
    freq_sel = 2'b01;
    for (int i = 0; i < 140; i++) step(0, 0, 1, 0, 0, 6, "R7 512 Hz tap");
    freq_sel = 2'b00;
    step(0, 0, 0, 0, 0, 15, "R7 1 Hz tap before half period");
    for (int i = 0; i < 32768; i++) step(0, 0, 1, 0, 0, -1, "", 0);
    step(0, 0, 0, 0, 0, 15, "R7 1 Hz tap after half period");
    step(0, 0, 1, 0, 0, 15, "R11 1 Hz tap next count");

    repeat (2) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule